// File: doc/BRIEF.md
# Minus-Two-Log Fixed-Point Evaluator

This block takes a 48-bit unsigned fraction `u`, read as U/2^48 in [0, 1), and returns `e = -2·ln(u)`. This is the radius-squared term of a Box-Muller Gaussian generator. A leading-one search scales the input into a mantissa m in [1, 2), so that u = m·2^-(k+1), where k is the count of leading zeros. The top eight mantissa fraction bits pick one of 256 equal-width segments. Within the chosen segment, ln(m) is formed by a quadratic in Horner order from three per-segment constants. These constants are computed while the design elaborates.

The result is then rebuilt as 2·((k+1)·ln2 − ln m). The doubling is a one-place shift. The pipeline accepts one sample on every clock and delivers each result exactly three cycles later. A valid flag travels alongside each sample. A zero input has no finite logarithm, so it yields the largest code the output can hold.

Top module: `neg2ln_eval`

## Requirements
- R1: While reset is held, and after it is released until the first result leaves, `out_valid` is 0 and `e` is 0.
- R2: `out_valid` is exactly `in_valid` delayed by three clock cycles. A sample is taken on every cycle where `in_valid` is 1, with no stall, and every accepted sample produces one result.
- R3: For nonzero `u`, `e` is unsigned fixed point with 7 integer bits and 24 fraction bits. It is within 3 LSB (3·2^-24) of −2·ln(U/2^48).
- R4: A zero `u` yields `e` equal to all ones (0x7FFFFFFF).
- R5: A `u` with a single set bit at position 48−n, which is 2^-n, gives 2n·ln2 within 3 LSB, for every n from 1 to 48.
- R6: The eight bits directly below the leading one of `u` select the segment. Inputs in every one of the 256 segments, at more than one leading-zero count, are accurate to 3 LSB.
- R7: Inputs just below one, whose true result lies within a few LSB of zero, give a result within 3 LSB of the truth. The result never wraps to a large value.
- R8: In every cycle where `out_valid` is 0, `e` keeps the value it had in the previous cycle.
- R9: Back-to-back samples do not disturb each other. A mix of zero, minimum nonzero and near-one inputs on consecutive cycles gives each its own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| in_valid | input | 1 | `u` carries a sample this cycle |
| u | input | 48 | Unsigned fraction, value U/2^48 |
| out_valid | output | 1 | `e` carries a result this cycle |
| e | output | 31 | −2·ln(u), unsigned with 7 integer and 24 fraction bits |

## Verification
Two paths can be active in the pipeline in the same cycle. One is the zero-input saturation path. The other is the clamp that stops a near-one input from going negative. They occupy adjacent stages when a zero and an all-ones input arrive on consecutive cycles. The bench drives such alternating bursts with no gaps, so that one sample is being forced to all ones while its neighbour is being clamped. Each result is judged on its own against a real-valued logarithm, or against the all-ones code for zero. Idle cycles are also placed among streaming segment sweeps, and the output is required to hold during those gaps while new samples keep entering.

// File: rtl/neg2ln_pkg.sv
package neg2ln_pkg;

  // working precision of the elaboration-time coefficient arithmetic
  localparam int unsigned ACC_F = 48;

  // right shift with round-half-up
  function automatic logic [127:0] rnd_shr(input logic [127:0] v, input int unsigned s);
    return (v + (128'(1) << (s - 1))) >> s;
  endfunction

  // left edge of segment j (of 2^iw) in [1,2), scaled by 2^ACC_F
  function automatic logic [127:0] seg_base(input int unsigned j, input int unsigned iw);
    return (128'(1) << ACC_F) + (128'(j) << (ACC_F - iw));
  endfunction

  // natural log of a (scaled 2^ACC_F, a >= 1) through the atanh series
  function automatic logic [127:0] ln_fixed(input logic [127:0] a);
    logic [127:0] one;
    logic [127:0] z;
    logic [127:0] z2;
    logic [127:0] p;
    logic [127:0] s;
    one = 128'(1) << ACC_F;
    z   = ((a - one) << ACC_F) / (a + one);
    z2  = (z * z) >> ACC_F;
    p   = z;
    s   = z;
    for (int n = 1; n < 20; n++) begin
      p = (p * z2) >> ACC_F;
      s = s + p / 128'(2 * n + 1);
    end
    return s << 1;
  endfunction

  // reciprocal of the segment base, scaled 2^ACC_F
  function automatic logic [127:0] seg_recip(input int unsigned j, input int unsigned iw);
    return (128'(1) << (2 * ACC_F)) / seg_base(j, iw);
  endfunction

endpackage

// File: rtl/neg2ln_norm.sv
module neg2ln_norm #(
  parameter int unsigned W = 48,
  localparam int unsigned KW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  output logic [KW-1:0] lz,
  output logic          is_zero,
  output logic [W-1:0]  shifted
);

  // ascending scan: the highest set bit is the last to write lz
  always_comb begin
    lz      = '0;
    is_zero = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (val[i]) begin
        lz      = KW'(W - 1 - i);
        is_zero = 1'b0;
      end
    end
    shifted = val << lz;
  end

endmodule

// File: rtl/neg2ln_coef_rom.sv
module neg2ln_coef_rom
  import neg2ln_pkg::*;
#(
  parameter int unsigned IW = 8,
  parameter int unsigned CW = 32
) (
  input  logic [IW-1:0] idx,
  output logic [CW-1:0] c0,
  output logic [CW:0]   c1,
  output logic [CW-1:0] c2
);

  localparam int unsigned NSEG = 1 << IW;

  logic [CW-1:0] c0_tab [NSEG];
  logic [CW:0]   c1_tab [NSEG];
  logic [CW-1:0] c2_tab [NSEG];

  // Taylor terms at each segment base a: ln a, 1/a, 1/(2a^2)
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam logic [127:0] RCP = seg_recip(g, IW);
    localparam logic [127:0] C0V = rnd_shr(ln_fixed(seg_base(g, IW)), ACC_F - CW);
    localparam logic [127:0] C1V = rnd_shr(RCP, ACC_F - CW);
    localparam logic [127:0] C2V = rnd_shr(RCP * RCP, 2 * ACC_F + 1 - CW);
    assign c0_tab[g] = C0V[CW-1:0];
    assign c1_tab[g] = C1V[CW:0];
    assign c2_tab[g] = C2V[CW-1:0];
  end

  assign c0 = c0_tab[idx];
  assign c1 = c1_tab[idx];
  assign c2 = c2_tab[idx];

endmodule

// File: rtl/neg2ln_mulhi.sv
module neg2ln_mulhi #(
  parameter int unsigned AW = 32,
  parameter int unsigned BW = 24,
  parameter int unsigned SH = 32
) (
  input  logic [AW-1:0]       a,
  input  logic [BW-1:0]       b,
  output logic [AW+BW-SH-1:0] hi
);

  logic [AW+BW-1:0] full;
  logic             unused_lo;

  assign full      = (AW+BW)'(a) * (AW+BW)'(b);
  assign hi        = full[AW+BW-1:SH];
  assign unused_lo = ^full[SH-1:0];

endmodule

// File: rtl/neg2ln_eval.sv
module neg2ln_eval
  import neg2ln_pkg::*;
#(
  parameter int unsigned UW  = 48,
  parameter int unsigned IW  = 8,
  parameter int unsigned XW  = 24,
  parameter int unsigned OIB = 7,
  parameter int unsigned OFB = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [UW-1:0]        u,
  output logic                 out_valid,
  output logic [OIB+OFB-1:0]   e
);

  localparam int unsigned KW  = $clog2(UW);
  localparam int unsigned CW  = IW + XW;          // fraction bits of internal terms
  localparam int unsigned OW  = OIB + OFB;
  localparam int unsigned DW  = CW + KW + 1;      // width of (k+1)*ln2
  localparam int unsigned SHR = CW - OFB - 1;     // doubling folded into the final slice
  localparam logic [127:0]  LN2_R = rnd_shr(ln_fixed(128'(2) << ACC_F), ACC_F - CW);
  localparam logic [CW-1:0] LN2   = LN2_R[CW-1:0];

  // ---------------- reset release ----------------
  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  // ---------------- stage 1: range reduction ----------------
  logic [KW-1:0] n_lz;
  logic          n_zero;
  logic [UW-1:0] n_shift;

  neg2ln_norm #(.W(UW)) u_norm (
    .val     (u),
    .lz      (n_lz),
    .is_zero (n_zero),
    .shifted (n_shift)
  );

  logic          s1_vld_d, s1_vld_q, s1_ce;
  logic          s1_zero_d, s1_zero_q;
  logic [KW-1:0] s1_k_d, s1_k_q;
  logic [IW-1:0] s1_idx_d, s1_idx_q;
  logic [XW-1:0] s1_x_d, s1_x_q;

  always_comb begin
    s1_vld_d  = in_valid;
    s1_ce     = in_valid;
    s1_zero_d = n_zero;
    s1_k_d    = n_lz;
    s1_idx_d  = n_shift[UW-2 -: IW];
    s1_x_d    = n_shift[UW-2-IW -: XW];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      s1_vld_q  <= 1'b0;
      s1_zero_q <= 1'b0;
      s1_k_q    <= '0;
      s1_idx_q  <= '0;
      s1_x_q    <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      if (s1_ce) begin
        s1_zero_q <= s1_zero_d;
        s1_k_q    <= s1_k_d;
        s1_idx_q  <= s1_idx_d;
        s1_x_q    <= s1_x_d;
      end
    end
  end

  // ---------------- stage 2: table and inner Horner step ----------------
  logic [CW-1:0] r_c0;
  logic [CW:0]   r_c1;
  logic [CW-1:0] r_c2;
  logic [XW-1:0] c2x;

  neg2ln_coef_rom #(.IW(IW), .CW(CW)) u_rom (
    .idx (s1_idx_q),
    .c0  (r_c0),
    .c1  (r_c1),
    .c2  (r_c2)
  );

  neg2ln_mulhi #(.AW(CW), .BW(XW), .SH(CW)) u_mul_in (
    .a  (r_c2),
    .b  (s1_x_q),
    .hi (c2x)
  );

  logic          s2_vld_d, s2_vld_q, s2_ce;
  logic          s2_zero_d, s2_zero_q;
  logic [KW-1:0] s2_k_d, s2_k_q;
  logic [CW:0]   s2_t_d, s2_t_q;
  logic [CW-1:0] s2_c0_d, s2_c0_q;
  logic [XW-1:0] s2_x_d, s2_x_q;

  always_comb begin
    s2_vld_d  = s1_vld_q;
    s2_ce     = s1_vld_q;
    s2_zero_d = s1_zero_q;
    s2_k_d    = s1_k_q;
    s2_t_d    = r_c1 - (CW+1)'(c2x);  // slope minus curvature term
    s2_c0_d   = r_c0;
    s2_x_d    = s1_x_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      s2_vld_q  <= 1'b0;
      s2_zero_q <= 1'b0;
      s2_k_q    <= '0;
      s2_t_q    <= '0;
      s2_c0_q   <= '0;
      s2_x_q    <= '0;
    end else begin
      s2_vld_q <= s2_vld_d;
      if (s2_ce) begin
        s2_zero_q <= s2_zero_d;
        s2_k_q    <= s2_k_d;
        s2_t_q    <= s2_t_d;
        s2_c0_q   <= s2_c0_d;
        s2_x_q    <= s2_x_d;
      end
    end
  end

  // ---------------- stage 3: outer Horner step and reconstruction ----------------
  logic [XW:0]   tx;
  logic [CW:0]   lnm;
  logic [KW:0]   kp1;
  logic [DW-1:0] kterm;
  logic [DW-1:0] diff;
  logic          unused_bits;

  neg2ln_mulhi #(.AW(CW+1), .BW(XW), .SH(CW)) u_mul_out (
    .a  (s2_t_q),
    .b  (s2_x_q),
    .hi (tx)
  );

  logic          o_vld_d, o_vld_q, o_ce;
  logic [OW-1:0] o_e_d, o_e_q;

  always_comb begin
    lnm   = (CW+1)'(s2_c0_q) + (CW+1)'(tx);
    kp1   = (KW+1)'(s2_k_q) + (KW+1)'(1);
    kterm = DW'(kp1) * DW'(LN2);
    if (kterm >= DW'(lnm)) diff = kterm - DW'(lnm);
    else                   diff = '0;
    o_vld_d = s2_vld_q;
    o_ce    = s2_vld_q;
    if (s2_zero_q) o_e_d = '1;
    else           o_e_d = diff[SHR +: OW];
  end

  assign unused_bits = ^{diff, n_shift[UW-1], n_shift[UW-IW-XW-2:0]};

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      o_vld_q <= 1'b0;
      o_e_q   <= '0;
    end else begin
      o_vld_q <= o_vld_d;
      if (o_ce) o_e_q <= o_e_d;
    end
  end

  assign out_valid = o_vld_q;
  assign e         = o_e_q;

endmodule

// File: rtl/neg2ln_eval_chk.sv
module neg2ln_eval_chk #(
  parameter int unsigned UW  = 48,
  parameter int unsigned OFB = 24,
  parameter int unsigned OW  = 31
) (
  input logic          clk,
  input logic          srst_n,
  input logic          in_valid,
  input logic [UW-1:0] u,
  input logic          out_valid,
  input logic [OW-1:0] e
);

  localparam logic [OW-1:0] E_MAX = OW'(longint'((7 * UW) / 5 + 1) << OFB);

  logic [1:0] warm;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)            warm <= '0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  always @(posedge clk) begin
    if (!srst_n) begin
      a_r1_idle: assert (!out_valid && e == '0);
    end
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (!srst_n)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r4_zero_sat: assert property (@(posedge clk) disable iff (!srst_n)
    (warm == 2'd3 && $past(in_valid, 3) && $past(u, 3) == '0) |-> (e == {OW{1'b1}}));

  a_r3_range: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && e != {OW{1'b1}}) |-> (e <= E_MAX));

  a_r8_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (warm != 2'd0 && !out_valid) |-> $stable(e));

endmodule

bind neg2ln_eval neg2ln_eval_chk #(.UW(UW), .OFB(OFB), .OW(OW)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .in_valid  (in_valid),
  .u         (u),
  .out_valid (out_valid),
  .e         (e)
);

// File: tb/neg2ln_eval_tb.sv
module neg2ln_eval_tb;

  localparam int CLK_P = 10;
  localparam int UW    = 48;
  localparam int OW    = 31;
  localparam int OFB   = 24;
  localparam int QD    = 8192;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [UW-1:0] u;
  logic          out_valid;
  logic [OW-1:0] e;

  neg2ln_eval u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .u         (u),
    .out_valid (out_valid),
    .e         (e)
  );

  int            n_chk;
  int            n_bad;
  int            wr;
  int            rd;
  logic [UW-1:0] q_u   [QD];
  string         q_tag [QD];
  logic [2:0]    vh;
  logic [OW-1:0] last_e;
  logic          mon_on;
  logic [63:0]   rs;

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  always @(posedge clk) vh <= {vh[1:0], in_valid};

  function automatic logic [63:0] xs(input logic [63:0] x);
    x ^= x << 13;
    x ^= x >> 7;
    x ^= x << 17;
    return x;
  endfunction

  task automatic note(input bit ok, input string tag, input string what,
                      input real act, input real expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", tag, what, act, expv);
    end
  endtask

  task automatic check_val(input logic [UW-1:0] uv, input string tag);
    real ex;
    real got;
    got = real'(e);
    if (uv == '0) begin
      note(e == {OW{1'b1}}, tag, "zero saturation", got, real'({OW{1'b1}}));
    end else begin
      ex = -2.0 * $ln(real'(uv) / (2.0 ** UW)) * (2.0 ** OFB);
      note((got - ex <= 3.0) && (ex - got <= 3.0), tag, "value", got, ex);
    end
  endtask

  // R2 latency and R8 hold are judged every cycle; values on every output
  always @(negedge clk) begin
    if (mon_on) begin
      note(out_valid == vh[2], "R2", "valid latency", real'(out_valid), real'(vh[2]));
      if (out_valid) begin
        if (rd == wr) note(1'b0, "R2", "result without sample", 1.0, 0.0);
        else begin
          check_val(q_u[rd % QD], q_tag[rd % QD]);
          rd++;
        end
      end else begin
        note(e == last_e, "R8", "hold while idle", real'(e), real'(last_e));
      end
      last_e = e;
    end
  end

  task automatic send(input bit v, input logic [UW-1:0] uv, input string tag);
    @(posedge clk);
    #1;
    in_valid = v;
    u        = uv;
    if (v) begin
      q_u[wr % QD]   = uv;
      q_tag[wr % QD] = tag;
      wr++;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL R2 watchdog: actual %0d results expected %0d", rd, wr);
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; wr = 0; rd = 0;
    rst_n = 1'b1; in_valid = 1'b0; u = '0; vh = '0;
    mon_on = 1'b0; last_e = '0;
    rs = 64'h9E37_79B9_7F4A_7C15;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    note(!out_valid && e == '0, "R1", "outputs in reset", real'(e), 0.0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    note(!out_valid && e == '0, "R1", "outputs after release", real'(e), 0.0);
    last_e = e;
    #1 mon_on = 1'b1;

    // R5: every leading-zero count, exact powers of two
    for (int n = 1; n <= UW; n++) send(1'b1, UW'(1) << (UW - n), "R5");

    // R6: all segments at two leading-zero counts, with idle gaps for R8
    for (int kk = 0; kk < 2; kk++) begin
      for (int j = 0; j < 256; j++) begin
        rs = xs(rs);
        send(1'b1, {1'b1, 8'(j), rs[38:0]} >> (kk * 17), "R6");
        if (j % 7 == 3) send(1'b0, rs[47:0], "R8");
      end
    end

    // R4 / R7 / R9: zero, near-one and extremes back to back
    send(1'b1, '0, "R4");
    send(1'b1, '1, "R7");
    send(1'b1, '0, "R4");
    send(1'b1, '0, "R4");
    send(1'b1, 48'h1, "R9");
    send(1'b1, '1, "R7");
    send(1'b1, 48'h8000_0000_0000, "R9");
    send(1'b1, '0, "R4");
    send(1'b1, 48'hFFFF_FFFF_FFF0, "R7");
    send(1'b1, 48'hFFFF_0000_0000, "R9");

    // R3: random fractions over the whole dynamic range, random valid
    for (int i = 0; i < 3000; i++) begin
      rs = xs(rs);
      send(rs[57:56] != 2'b00, rs[47:0] >> (rs[63:58] % 48), "R3");
    end

    for (int i = 0; i < 8; i++) send(1'b0, '0, "R8");
    @(negedge clk);
    #1;
    note(rd == wr, "R2", "every sample returned", real'(rd), real'(wr));
    finish_run();
  end

endmodule